// File: doc/BRIEF.md
# Windowed Input-Queue Cell Scheduler

This block decides, once per time-slot, which queued cells of an input-buffered switch cross the fabric. Each of the N input queues shows the scheduler its first WIN cells: a destination port and a valid flag for each window position. The scheduler builds a set of grants in which no input and no output is used twice. A head cell that loses its output no longer stalls its whole input, because a cell further back in the same queue may still be sent to an output that nobody else has claimed. The queues can therefore remove a cell from any window position.

The matching works in passes. First every input's head cell is tried, then every input's second cell, and so on. Within each pass the inputs are visited starting from a rotating pointer. The pointer moves on by one input per slot, so that no input is always first in line. The caller raises `slot_start` for one clock with the candidate vectors valid. On the next clock edge the result is registered: a per-input grant flag, the chosen window position and its destination. The grant stays visible until the next slot. For the one clock after each slot, a per-input dequeue strobe tells each granted queue to drop the chosen cell.

A small controller sequences the outputs. It has three states. IDLE means no slot has been scheduled since reset. PULSE is the single clock after a slot was sampled, when the dequeue strobes are driven. HOLD means the grant is being held with the strobes low. The transitions are:
- IDLE to PULSE, PULSE to PULSE and HOLD to PULSE, each on `slot_start`.
- PULSE to HOLD when `slot_start` is low.
- IDLE stays in IDLE and HOLD stays in HOLD while `slot_start` is low.

Top module: `win_cell_sched`

## Requirements
- R1: After reset, `grant_vld` and `deq_stb` are all zero and the rotating start pointer is input 0.
- R2: A slot sampled on `slot_start` at clock edge k produces its grants on the outputs from edge k, visible in the cycle that follows. It is not visible earlier.
- R3: For each input i, `grant_pos[i]` gives the window position of the granted cell (0 = head). `grant_dst[i*2 +: 2]` gives that cell's destination port. Candidate entry e = i*WIN + p uses `cand_vld[e]` and `cand_dst[e*2 +: 2]`. An input receives at most one grant per slot.
- R4: No two inputs granted in the same slot have the same destination port.
- R5: A window entry whose valid flag is low is never granted, even when its destination port is free.
- R6: Window position 0 is tried for all inputs before position 1. A deeper cell can only take an output that no head cell claimed in the same slot.
- R7: Within each pass, inputs are visited in the order ptr, ptr+1, … modulo N. The pointer advances by one on every slot and wraps from N-1 to 0.
- R8: In the clock after a sampled slot, `deq_stb` equals the new `grant_vld`. In every other cycle it is zero. This includes back-to-back slots, where it stays high for each of them.
- R9: An input whose head cell loses its output is granted its next valid window cell if that cell's output is still free.
- R10: While `slot_start` is low, the grant outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start | input | 1 | Sample candidates and schedule one slot |
| cand_vld | input | N_PORTS*WIN | Valid flag per window entry (entry = input*WIN + position) |
| cand_dst | input | N_PORTS*WIN*PORT_W | Destination port per window entry |
| grant_vld | output | N_PORTS | Input granted in the current slot |
| grant_pos | output | N_PORTS*POS_W | Window position granted per input |
| grant_dst | output | N_PORTS*PORT_W | Destination of the granted cell per input |
| deq_stb | output | N_PORTS | One-cycle dequeue strobe per granted input |

## Verification
Two things can fall in the same clock: the dequeue pulse of one slot and the sampling of the next slot. This happens when `slot_start` is raised again during the PULSE cycle. The bench provokes it by issuing two slots on consecutive clocks, with the pointer at 0 and then at 1.
- Each strobe must follow the grant set of its own slot.
- The second grant set must reflect the advanced pointer.
- The strobes must drop to zero in the first cycle without a slot.

The stimulus table also covers the following:
- rotation across consecutive slots;
- bypass of blocked heads;
- invalid entries whose outputs are free;
- a deeper cell losing to another input's head.

// File: rtl/win_sched_pkg.sv
package win_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } sched_st_e;

endpackage

// File: rtl/wqs_rotor.sv
module wqs_rotor #(
    parameter int N_PORTS = 4,
    parameter int PORT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [PORT_W-1:0] ptr
);
    localparam logic [PORT_W-1:0] LAST = PORT_W'(N_PORTS - 1);

    logic [PORT_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    // R7
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

endmodule

// File: rtl/wqs_match.sv
module wqs_match #(
    parameter int N_PORTS = 4,
    parameter int WIN     = 2,
    parameter int PORT_W  = 2,
    parameter int POS_W   = 1
) (
    input  logic [PORT_W-1:0]            ptr,
    input  logic [N_PORTS*WIN-1:0]       cand_vld,
    input  logic [N_PORTS*WIN*PORT_W-1:0] cand_dst,
    output logic [N_PORTS-1:0]           m_gv,
    output logic [N_PORTS*POS_W-1:0]     m_pos,
    output logic [N_PORTS*PORT_W-1:0]    m_dst
);
    localparam int OUT_SLOTS = 1 << PORT_W;

    logic [N_PORTS-1:0]   in_taken;
    logic [OUT_SLOTS-1:0] out_taken;

    // Pass p tries window position p for every input, rotating start.
    always_comb begin
        in_taken  = '0;
        out_taken = '0;
        m_gv      = '0;
        m_pos     = '0;
        m_dst     = '0;
        for (int p = 0; p < WIN; p++) begin
            for (int k = 0; k < N_PORTS; k++) begin
                automatic int               idx = (int'(ptr) + k) % N_PORTS;
                automatic int               ent = idx * WIN + p;
                automatic logic [PORT_W-1:0] d  = cand_dst[ent*PORT_W +: PORT_W];
                if (!in_taken[idx] && cand_vld[ent] && !out_taken[d]) begin
                    in_taken[idx]                    = 1'b1;
                    out_taken[d]                     = 1'b1;
                    m_gv[idx]                        = 1'b1;
                    m_pos[idx*POS_W +: POS_W]        = POS_W'(p);
                    m_dst[idx*PORT_W +: PORT_W]      = d;
                end
            end
        end
    end

endmodule

// File: rtl/win_cell_sched.sv
module win_cell_sched
    import win_sched_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int WIN     = 2,
    parameter int PORT_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    parameter int POS_W   = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_start,
    input  logic [N_PORTS*WIN-1:0]        cand_vld,
    input  logic [N_PORTS*WIN*PORT_W-1:0] cand_dst,
    output logic [N_PORTS-1:0]            grant_vld,
    output logic [N_PORTS*POS_W-1:0]      grant_pos,
    output logic [N_PORTS*PORT_W-1:0]     grant_dst,
    output logic [N_PORTS-1:0]            deq_stb
);
    sched_st_e                     state_q, state_d;
    logic [PORT_W-1:0]             ptr;
    logic [N_PORTS-1:0]            m_gv, gv_q;
    logic [N_PORTS*POS_W-1:0]      m_pos, pos_q;
    logic [N_PORTS*PORT_W-1:0]     m_dst, dst_q;

    wqs_rotor #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) rotor_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (slot_start),
        .ptr   (ptr)
    );

    wqs_match #(.N_PORTS(N_PORTS), .WIN(WIN), .PORT_W(PORT_W), .POS_W(POS_W)) match_i (
        .ptr      (ptr),
        .cand_vld (cand_vld),
        .cand_dst (cand_dst),
        .m_gv     (m_gv),
        .m_pos    (m_pos),
        .m_dst    (m_dst)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = slot_start ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = slot_start ? ST_PULSE : ST_HOLD;
            ST_HOLD:  state_d = slot_start ? ST_PULSE : ST_HOLD;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gv_q    <= '0;
            pos_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (slot_start) begin
                gv_q  <= m_gv;
                pos_q <= m_pos;
                dst_q <= m_dst;
            end
        end
    end

    always_comb begin
        grant_vld = gv_q;
        grant_pos = pos_q;
        grant_dst = dst_q;
        deq_stb   = (state_q == ST_PULSE) ? gv_q : '0;
    end

    // R8
    deq_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> deq_stb == grant_vld);

    // R8
    deq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_stb != '0) |-> $past(slot_start));

    // R10
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> ($stable(grant_vld) && $stable(grant_pos) && $stable(grant_dst)));

    generate
        for (genvar a = 0; a < N_PORTS; a++) begin : g_pair_a
            for (genvar b = a + 1; b < N_PORTS; b++) begin : g_pair_b
                // R4
                out_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant_vld[a] && grant_vld[b]) |->
                    (grant_dst[a*PORT_W +: PORT_W] != grant_dst[b*PORT_W +: PORT_W]));
            end
            for (genvar p = 0; p < WIN; p++) begin : g_win
                // R5
                no_invalid_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (slot_start && !cand_vld[a*WIN+p]) |=>
                    !(grant_vld[a] && grant_pos[a*POS_W +: POS_W] == POS_W'(p)));
            end
        end
    endgenerate

endmodule

// File: tb/win_cell_sched_tb_top.sv
`timescale 1ns/1ps
module win_cell_sched_tb_top;
    localparam int N = 4;
    localparam int W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_start = 1'b0;
    logic [7:0]  cand_vld = '0;
    logic [15:0] cand_dst = '0;
    logic [3:0]  grant_vld;
    logic [3:0]  grant_pos;
    logic [7:0]  grant_dst;
    logic [3:0]  deq_stb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    win_cell_sched #(.N_PORTS(N), .WIN(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
        .cand_vld(cand_vld), .cand_dst(cand_dst),
        .grant_vld(grant_vld), .grant_pos(grant_pos),
        .grant_dst(grant_dst), .deq_stb(deq_stb)
    );

    // {vld[8], dst[16], exp_gv[4], exp_pos[4], exp_dst[8]}; ptr runs 0,1,2,3,0
    localparam logic [39:0] VEC [5] = '{
        {8'hFF, 16'hDD88, 4'hF, 4'hA, 8'hD8},  // ptr0: head bypass R9, R6
        {8'hFF, 16'hDD88, 4'hF, 4'h9, 8'hD2},  // ptr1: rotation R7
        {8'hC6, 16'hA0E8, 4'h8, 4'h0, 8'h80},  // ptr2: invalid entries R5
        {8'h00, 16'hFFFF, 4'h0, 4'h0, 8'h00},  // ptr3: nothing valid R5
        {8'h06, 16'h0014, 4'h2, 4'h0, 8'h04}   // ptr0: head beats deeper R6
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dst_mask(input logic [3:0] gv);
        logic [7:0] m = '0;
        for (int i = 0; i < 4; i++) if (gv[i]) m[i*2 +: 2] = 2'b11;
        return m;
    endfunction

    task automatic check_grant(input logic [39:0] v, input string tag);
        logic [7:0] mk = dst_mask(v[15:12]);
        chk(grant_vld == v[15:12], {tag, " R2 R4 grant_vld"}, 32'(grant_vld), 32'(v[15:12]));
        chk((grant_pos & v[15:12]) == v[11:8], {tag, " R3 R6 grant_pos"}, 32'(grant_pos & v[15:12]), 32'(v[11:8]));
        chk((grant_dst & mk) == v[7:0], {tag, " R3 R4 grant_dst"}, 32'(grant_dst & mk), 32'(v[7:0]));
        chk(deq_stb == v[15:12], {tag, " R8 deq pulse"}, 32'(deq_stb), 32'(v[15:12]));
    endtask

    task automatic issue(input logic [39:0] v);
        cand_vld   = v[39:32];
        cand_dst   = v[31:16];
        slot_start = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] g_hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(grant_vld == 4'h0, "R1 grant after reset", 32'(grant_vld), 0);
        chk(deq_stb == 4'h0, "R1 deq after reset", 32'(deq_stb), 0);

        foreach (VEC[n]) begin
            issue(VEC[n]);
            @(posedge clk);
            @(negedge clk);
            slot_start = 1'b0;
            cand_vld   = 8'hFF; // changes while idle must not matter (R10)
            check_grant(VEC[n], $sformatf("vec%0d", n));
            g_hold = grant_vld;
            @(posedge clk);
            @(negedge clk);
            chk(deq_stb == 4'h0, "R8 deq single cycle", 32'(deq_stb), 0);
            chk(grant_vld == g_hold, "R10 grant held", 32'(grant_vld), 32'(g_hold));
        end

        // R1: mid-run reset clears grants and returns pointer to 0
        rst_n = 1'b0;
        @(negedge clk);
        chk(grant_vld == 4'h0, "R1 grant cleared", 32'(grant_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // back-to-back slots: sample during dequeue pulse (R7, R8, R2)
        issue(VEC[0]);
        @(posedge clk);
        @(negedge clk);
        check_grant(VEC[0], "b2b first R1 ptr0");
        issue(VEC[1]);
        @(posedge clk);
        @(negedge clk);
        slot_start = 1'b0;
        check_grant(VEC[1], "b2b second R7");
        @(posedge clk);
        @(negedge clk);
        chk(deq_stb == 4'h0, "R8 deq drops after b2b", 32'(deq_stb), 0);
        chk(grant_vld == 4'hF, "R10 grant held after b2b", 32'(grant_vld), 32'hF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule